// File: doc/BRIEF.md
# Peripheral Interrupt Controller with Type and Polarity

This block gathers eight interrupt lines from one peripheral and turns them into a single request toward an upstream accumulator. Each source can be set to edge or level sensing. Two separate polarity bits select the active edge or level. For an edge source they enable rising detection, falling detection, or both.

Each detected event sets a sticky latched bit. The request output is raised while any latched bit is also enabled. Software sets and clears the enable mask through two separate addresses, one for setting and one for clearing. It clears latched bits with write-one-to-clear. A two-byte write that starts at the latched-clear address also reaches the enable-set register, so a source can be cleared and enabled in a single access.

All register access goes through a byte-addressed port that has no back-pressure. Every write completes in the cycle it is presented. Every read returns one cycle later, flagged by `reg_rvalid`.

Top module: `pic_periph_ctrl`

## Requirements
- R1: After reset the type, polarity-high, polarity-low, enable and latched registers all read 0, and `irq_out` is low.
- R2: A read at address 0x10 returns the levels that `src_lines` had at the clock edge where the read was taken. Every read asserts `reg_rvalid` with its data in the following cycle.
- R3: The type register (0x11), the polarity-high register (0x12) and the polarity-low register (0x13) read back the value last written to them.
- R4: For a source whose type bit is 1 (edge) and whose polarity-high bit is 1, a rising edge on its line sets its latched bit. With its polarity-low bit at 0, a falling edge does not set it.
- R5: For an edge source, a polarity-low bit of 1 latches falling edges. With both polarity bits set, both edges latch.
- R6: For a source whose type bit is 0 (level), the latched bit is set while the line is high when polarity-high is 1, and while it is low when polarity-low is 1. After a clear it reads 0 for one cycle, then sets again if the line is still active.
- R7: Writing 1s to address 0x14 clears the matching latched bits. A clear beats a detection in the same cycle. Bits written as 0 leave their latched bits unchanged.
- R8: Writing 1s to 0x15 sets enable bits and writing 1s to 0x16 clears them. A clear wins when both reach the same bit. Reading either address returns the enable mask.
- R9: `irq_out` is high exactly when some source is both latched and enabled. Latching happens whether or not the source is enabled.
- R10: A two-byte write at 0x14 applies its low byte as a latched clear and its high byte as an enable set in the same cycle. A stale latched bit therefore never raises `irq_out` when it is enabled this way.
- R11: A read at 0x18 returns the latched status. Reads at 0x14 and at unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lines | input | NSRC | Raw interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wide | input | 1 | Write also targets reg_addr+1 with the high data byte |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data; low byte to reg_addr, high byte to reg_addr+1 |
| reg_rdata | output | 8 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq_out | output | 1 | Interrupt request toward the accumulator |

## Verification
The hardest situations to reach are the ones where a clear races a detection. One is the one-cycle gap in a level source that is still active after a clear. The other is the stale latch that a combined clear-and-enable must hide. The stimulus holds a level line active, issues the clear, and reads the latched status on the very next cycle and again on the one after. For the stale case, the stimulus leaves an edge source latched while it is disabled, then issues the two-byte write at the clear address and samples `irq_out` right after the access.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] A_LEVEL  = 8'h10;
  localparam logic [AW-1:0] A_KIND   = 8'h11;
  localparam logic [AW-1:0] A_POSHI  = 8'h12;
  localparam logic [AW-1:0] A_POSLO  = 8'h13;
  localparam logic [AW-1:0] A_LCLR   = 8'h14;
  localparam logic [AW-1:0] A_ENSET  = 8'h15;
  localparam logic [AW-1:0] A_ENCLR  = 8'h16;
  localparam logic [AW-1:0] A_LSTAT  = 8'h18;

  typedef struct packed {
    logic          vld;
    logic [DW-1:0] dat;
  } wbyte_t;
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile
  import pic_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic            wide,
  input  logic [AW-1:0]   addr,
  input  logic [2*DW-1:0] wdata,
  input  logic [NSRC-1:0] lines,
  input  logic [NSRC-1:0] latched,
  output logic [NSRC-1:0] kind,
  output logic [NSRC-1:0] pol_hi,
  output logic [NSRC-1:0] pol_lo,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] lclr,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  localparam int unsigned LANES = 2;

  logic [AW-1:0] lane_addr [LANES];
  logic          lane_vld  [LANES];
  logic [DW-1:0] lane_dat  [LANES];

  always_comb begin
    lane_addr[0] = addr;
    lane_addr[1] = addr + AW'(1);
    lane_vld[0]  = wr;
    lane_vld[1]  = wr & wide;
    lane_dat[0]  = wdata[DW-1:0];
    lane_dat[1]  = wdata[2*DW-1:DW];
  end

  function automatic wbyte_t pick(input logic [AW-1:0] target,
                                  input logic [AW-1:0] a0, input logic v0, input logic [DW-1:0] d0,
                                  input logic [AW-1:0] a1, input logic v1, input logic [DW-1:0] d1);
    wbyte_t r;
    r.vld = 1'b0;
    r.dat = '0;
    if (v0 && a0 == target) begin
      r.vld = 1'b1;
      r.dat = d0;
    end else if (v1 && a1 == target) begin
      r.vld = 1'b1;
      r.dat = d1;
    end
    return r;
  endfunction

  wbyte_t w_kind, w_hi, w_lo, w_lclr, w_set, w_clr;

  always_comb begin
    w_kind = pick(A_KIND,  lane_addr[0], lane_vld[0], lane_dat[0], lane_addr[1], lane_vld[1], lane_dat[1]);
    w_hi   = pick(A_POSHI, lane_addr[0], lane_vld[0], lane_dat[0], lane_addr[1], lane_vld[1], lane_dat[1]);
    w_lo   = pick(A_POSLO, lane_addr[0], lane_vld[0], lane_dat[0], lane_addr[1], lane_vld[1], lane_dat[1]);
    w_lclr = pick(A_LCLR,  lane_addr[0], lane_vld[0], lane_dat[0], lane_addr[1], lane_vld[1], lane_dat[1]);
    w_set  = pick(A_ENSET, lane_addr[0], lane_vld[0], lane_dat[0], lane_addr[1], lane_vld[1], lane_dat[1]);
    w_clr  = pick(A_ENCLR, lane_addr[0], lane_vld[0], lane_dat[0], lane_addr[1], lane_vld[1], lane_dat[1]);
  end

  logic [NSRC-1:0] set_m, clr_m;
  assign set_m = w_set.vld  ? w_set.dat[NSRC-1:0]  : '0;
  assign clr_m = w_clr.vld  ? w_clr.dat[NSRC-1:0]  : '0;
  assign lclr  = w_lclr.vld ? w_lclr.dat[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind   <= '0;
      pol_hi <= '0;
      pol_lo <= '0;
      en     <= '0;
    end else begin
      if (w_kind.vld) kind   <= w_kind.dat[NSRC-1:0];
      if (w_hi.vld)   pol_hi <= w_hi.dat[NSRC-1:0];
      if (w_lo.vld)   pol_lo <= w_lo.dat[NSRC-1:0];
      en <= (en | set_m) & ~clr_m;
    end
  end

  logic [DW-1:0] rmux;
  always_comb begin
    unique case (addr)
      A_LEVEL: rmux = DW'(lines);
      A_KIND:  rmux = DW'(kind);
      A_POSHI: rmux = DW'(pol_hi);
      A_POSLO: rmux = DW'(pol_lo);
      A_ENSET,
      A_ENCLR: rmux = DW'(en);
      A_LSTAT: rmux = DW'(latched);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? rmux : '0;
    end
  end
endmodule

// File: rtl/pic_detect.sv
module pic_detect #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lines,
  input  logic [NSRC-1:0] kind,
  input  logic [NSRC-1:0] pol_hi,
  input  logic [NSRC-1:0] pol_lo,
  output logic [NSRC-1:0] hit
);
  logic [NSRC-1:0] prev;

  // The previous sample follows the lines during reset, so a line that is
  // already high at release is not seen as an edge.
  always_ff @(posedge clk) begin
    prev <= lines;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic rise, fall, edge_hit, lvl_hit;
    always_comb begin
      rise     = lines[i] & ~prev[i];
      fall     = ~lines[i] & prev[i];
      edge_hit = (pol_hi[i] & rise) | (pol_lo[i] & fall);
      lvl_hit  = (pol_hi[i] & lines[i]) | (pol_lo[i] & ~lines[i]);
      hit[i]   = rst_n & (kind[i] ? edge_hit : lvl_hit);
    end
  end
endmodule

// File: rtl/pic_latch.sv
module pic_latch #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hit,
  input  logic [NSRC-1:0] lclr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] latched,
  output logic            irq
);
  // A clear beats a detection in the same cycle; an active level sets again next cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) latched <= '0;
    else        latched <= (latched | hit) & ~lclr;
  end

  assign irq = |(latched & en);
endmodule

// File: rtl/pic_periph_ctrl.sv
module pic_periph_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lines,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic            reg_wide,
  input  logic [AW-1:0]   reg_addr,
  input  logic [2*DW-1:0] reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            reg_rvalid,
  output logic            irq_out
);
  logic [NSRC-1:0] kind_q, hi_q, lo_q, en_q, lclr, hit, lat_q;

  pic_regfile #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .wide(reg_wide),
    .addr(reg_addr), .wdata(reg_wdata), .lines(src_lines), .latched(lat_q),
    .kind(kind_q), .pol_hi(hi_q), .pol_lo(lo_q), .en(en_q), .lclr(lclr),
    .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  pic_detect #(.NSRC(NSRC)) u_det (
    .clk(clk), .rst_n(rst_n), .lines(src_lines), .kind(kind_q),
    .pol_hi(hi_q), .pol_lo(lo_q), .hit(hit)
  );

  pic_latch #(.NSRC(NSRC)) u_lat (
    .clk(clk), .rst_n(rst_n), .hit(hit), .lclr(lclr), .en(en_q),
    .latched(lat_q), .irq(irq_out)
  );
endmodule

// File: rtl/pic_periph_ctrl_chk.sv
module pic_periph_ctrl_chk
  import pic_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_lines,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic            reg_wide,
  input logic [AW-1:0]   reg_addr,
  input logic [2*DW-1:0] reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic            reg_rvalid,
  input logic            irq_out,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] latched
);
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_level_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_LEVEL) |=> reg_rdata == DW'($past(src_lines)));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_LCLR) |=> (latched & $past(reg_wdata[NSRC-1:0])) == '0);

  assert_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wide && reg_addr == A_ENSET)
      |=> (en & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0]));

  assert_enable_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ENCLR) |=> (en & $past(reg_wdata[NSRC-1:0])) == '0);

  assert_no_stale_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wide && reg_addr == A_LCLR && en == '0
      && reg_wdata[NSRC-1:0] == reg_wdata[DW+NSRC-1:DW]) |=> !irq_out);
endmodule

bind pic_periph_ctrl pic_periph_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lines(src_lines), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wide(reg_wide), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
  .irq_out(irq_out), .en(en_q), .latched(lat_q)
);

// File: tb/sim_pic_periph_ctrl.sv
module sim_pic_periph_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  lines = '0;
  logic        wr = 1'b0, rd = 1'b0, wide = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  pic_periph_ctrl #(.NSRC(8)) u0 (
    .clk(clk), .rst_n(rst_n), .src_lines(lines), .reg_wr(wr), .reg_rd(rd),
    .reg_wide(wide), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .reg_rvalid(rvalid), .irq_out(irq)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [15:0] d, input logic w);
    wr = 1'b1; wide = w; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wide = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic drive(input logic [7:0] v);
    lines = v;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // Monitor: pops expected read data as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rvalid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL unexpected read data actual=%02h expected=none", rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rdata !== e) begin
            fails++;
            $display("FAIL %s read actual=%02h expected=%02h", t, rdata, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rreg(8'h15, 8'h00, "R1 enable");
    rreg(8'h18, 8'h00, "R1 latched");
    rreg(8'h11, 8'h00, "R1 type");
    rreg(8'h13, 8'h00, "R1 pol-low");

    // R2 real-time levels
    drive(8'hA5);
    rreg(8'h10, 8'hA5, "R2 levels A5");
    drive(8'h10);
    rreg(8'h10, 8'h10, "R2 levels 10");

    // R3 config: src0 edge rise, src1 edge fall, src2 edge both, src3 level high, src4 level low
    wreg(8'h11, 16'h0007, 1'b0);
    wreg(8'h12, 16'h000D, 1'b0);
    wreg(8'h13, 16'h0016, 1'b0);
    rreg(8'h11, 8'h07, "R3 type");
    rreg(8'h12, 8'h0D, "R3 pol-high");
    rreg(8'h13, 8'h16, "R3 pol-low");
    rreg(8'h18, 8'h00, "R3 no latch from config");

    // R4 rising edge
    drive(8'h11);
    rreg(8'h18, 8'h01, "R4 rise latched");
    wreg(8'h14, 16'h0001, 1'b0);
    drive(8'h10);
    rreg(8'h18, 8'h00, "R4 fall ignored");

    // R5 falling and both edges
    drive(8'h12);
    rreg(8'h18, 8'h00, "R5 rise ignored on fall source");
    drive(8'h10);
    rreg(8'h18, 8'h02, "R5 fall latched");
    drive(8'h14);
    rreg(8'h18, 8'h06, "R5 both-edge rise");
    wreg(8'h14, 16'h0006, 1'b0);
    drive(8'h10);
    rreg(8'h18, 8'h04, "R5 both-edge fall");
    wreg(8'h14, 16'h0004, 1'b0);

    // R6 level sources and re-latch after clear
    drive(8'h18);
    rreg(8'h18, 8'h08, "R6 level high");
    wreg(8'h14, 16'h0008, 1'b0);
    rreg(8'h18, 8'h00, "R6 gap after clear");
    rreg(8'h18, 8'h08, "R6 relatched");
    drive(8'h08);
    rreg(8'h18, 8'h18, "R6 level low");
    drive(8'h10);
    wreg(8'h14, 16'h00FF, 1'b0);
    rreg(8'h18, 8'h00, "R6 inactive stays clear");

    // R7 zero bits leave latches alone
    drive(8'h11);
    wreg(8'h14, 16'h0000, 1'b0);
    rreg(8'h18, 8'h01, "R7 zero write");
    wreg(8'h14, 16'h0001, 1'b0);
    rreg(8'h18, 8'h00, "R7 one clears");

    // R8 / R9 enables and request
    drive(8'h10);
    drive(8'h11);
    chk_irq(1'b0, "R9 latched but disabled");
    rreg(8'h18, 8'h01, "R9 latched while disabled");
    wreg(8'h15, 16'h0001, 1'b0);
    chk_irq(1'b1, "R9 enabled");
    rreg(8'h16, 8'h01, "R8 read clear addr");
    rreg(8'h15, 8'h01, "R8 read set addr");
    wreg(8'h16, 16'h0001, 1'b0);
    chk_irq(1'b0, "R8 disabled");
    wreg(8'h15, 16'h0203, 1'b1);
    rreg(8'h15, 8'h01, "R8 clear wins");
    chk_irq(1'b1, "R9 reenabled");
    wreg(8'h16, 16'h00FF, 1'b0);
    chk_irq(1'b0, "R8 all disabled");

    // R10 combined clear and enable hides stale latch
    rreg(8'h18, 8'h01, "R10 stale latch present");
    wreg(8'h14, 16'h0101, 1'b1);
    chk_irq(1'b0, "R10 no spurious request");
    rreg(8'h18, 8'h00, "R10 latch cleared");
    rreg(8'h15, 8'h01, "R10 enable set");
    drive(8'h10);
    drive(8'h11);
    chk_irq(1'b1, "R10 fresh edge raises request");

    // R11 latched status and unmapped reads
    rreg(8'h18, 8'h01, "R11 latched read");
    rreg(8'h14, 8'h00, "R11 clear addr reads 0");
    rreg(8'h17, 8'h00, "R11 unmapped 17");
    rreg(8'h00, 8'h00, "R11 unmapped 00");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL pending reads actual=%0d expected=0", exp_q.size());
    end
    summary();
  end
endmodule